// File: doc/BRIEF.md
# Green-Mode Jittered PWM Oscillator

This block sets the switching rhythm of a peak-current-mode flyback controller. Each switching period starts with a one-clock cycle-start strobe and a rising gate drive. The gate then falls when the on-time reaches its duty ceiling, or earlier when the current-limit comparator trips. For the first clocks of every on-time, a blanking window masks the turn-on spike so that the trip input has no effect. The feedback level arrives as an unsigned integer code. The analog slope ramp and the PWM comparator sit outside the block.

At heavy load the period is the nominal one. A slow triangular dither shifts it by a few clocks, with one offset held for each period. When the feedback code falls below a green threshold, the block lengthens only the off-time, in proportion to the shortfall, until the period reaches a ceiling (the frequency floor). At very low feedback a hysteretic burst detector suppresses gate pulses completely. After enable, a soft-start counter ramps the allowed peak-current code from zero to full scale.

Top module: `gm_pwm_osc`

## Requirements
- R1: During and after reset with `enable` low, `gate`, `blank` and `cycle_start` are 0 and `ilim` is 0.
- R2: With `fb_code >= GREEN_TH`, the distance between consecutive `cycle_start` pulses is `PERIOD_NOM + j` clocks, where `j` is the dither offset of that period.
- R3: With `fb_code < GREEN_TH`, the period grows by `min((GREEN_TH - fb_code) * GREEN_SLOPE, PERIOD_MAX - PERIOD_NOM)` clocks. The on-time ceiling stays the same as in R2.
- R4: The dither offset for period k after enable is a triangle wave. The step index is s = k / JIT_HOLD and p = s mod (4*JIT_AMP). The offset is p for p <= JIT_AMP, 2*JIT_AMP - p for p <= 3*JIT_AMP, and p - 4*JIT_AMP otherwise. An offset stays constant within a period.
- R5: With no trip, `gate` stays high for `floor((PERIOD_NOM + j) * DUTY_PM / 1000)` clocks from `cycle_start`.
- R6: `blank` is high for the first LEB_CYC clocks of every on-time. A trip that `cl_trip` samples while `blank` is high leaves the on-time unchanged.
- R7: A trip sampled while `gate` is high and `blank` is low drives `gate` low on the next clock. The following period runs to its full on-time, and the period length is unchanged.
- R8: A feedback code below ZD_OFF stops all gate pulses. Pulses resume only when the code is at or above ZD_ON. Codes in [ZD_OFF, ZD_ON) keep the current run or stop state.
- R9: While `enable` is high, `ilim` increases by 1 every SS_STEP clocks, starting from 0, and saturates at all ones.
- R10: With `enable` low, `gate` goes low on the next clock, `ilim` clears and the dither restarts. The first clock edge that samples `enable` high starts a new period.
- R11: `cycle_start` is a single-clock pulse that coincides with the first gate-high clock of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low idles the block and clears soft-start |
| fb_code | input | FB_W | Digitised feedback level |
| cl_trip | input | 1 | Current-limit comparator trip |
| gate | output | 1 | Gate drive |
| blank | output | 1 | Leading-edge blanking window |
| cycle_start | output | 1 | One-clock strobe at the start of each period |
| ilim | output | ILIM_W | Soft-start peak-current limit code |

## Verification
The period and on-time are measured at several feedback codes. The codes lie above the green threshold, exactly on it, one below it, along the linear off-time slope, at the first code that reaches the frequency floor and further below it. This separates a wrong slope, an off-by-one threshold, a missing cap, and an extension that wrongly shortens the on-time. A 24-period run at high feedback traces the whole dither triangle, so a wrong hold count, amplitude or turn-around point shows up. Trips are placed one clock inside and exactly at the end of blanking, and at mid on-time. Feedback is stepped through the burst band in both directions, so stop-and-resume hysteresis is told apart from a single threshold.

// File: rtl/gm_pwm_pkg.sv
// Package: shared types for the green-mode PWM oscillator.
// Assumes: nothing beyond a single synchronous clock domain.
package gm_pwm_pkg;

    // Where the switching period currently is.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // disabled, waiting for enable
        PH_ON   = 2'd1,  // gate driven high
        PH_OFF  = 2'd2,  // gate low for the rest of the period
        PH_SKIP = 2'd3   // burst stop: whole period without a pulse
    } phase_e;

endpackage

// File: rtl/gm_jitter.sv
// Module: triangular dither generator. Once per advance it steps a signed
// period offset one step towards +AMP or -AMP, after HOLD advances at
// each value, and turns around at the ends.
// Assumes: adv pulses once per switching period; clr restarts from zero, rising.
module gm_jitter #(
    parameter int AMP   = 3,
    parameter int HOLD  = 2,
    parameter int OFF_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    output logic signed [OFF_W-1:0] offset
);
    localparam int HC_W = $clog2(HOLD + 1);

    generate
        if (AMP == 0) begin : g_flat
            assign offset = '0;
        end else begin : g_sweep
            logic signed [OFF_W-1:0] off_q;
            logic                    up_q;
            logic [HC_W-1:0]         hc_q;

            // Step the offset along the triangle once every HOLD advances.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    off_q <= '0;
                    up_q  <= 1'b1;
                    hc_q  <= '0;
                end else if (adv) begin
                    if (hc_q == HC_W'(HOLD - 1)) begin
                        hc_q <= '0;
                        if (up_q) begin
                            if (off_q == OFF_W'(AMP)) begin
                                up_q  <= 1'b0;
                                off_q <= off_q - OFF_W'(1);
                            end else begin
                                off_q <= off_q + OFF_W'(1);
                            end
                        end else begin
                            if (off_q == OFF_W'(-AMP)) begin
                                up_q  <= 1'b1;
                                off_q <= off_q + OFF_W'(1);
                            end else begin
                                off_q <= off_q - OFF_W'(1);
                            end
                        end
                    end else begin
                        hc_q <= hc_q + HC_W'(1);
                    end
                end
            end

            assign offset = off_q;
        end
    endgenerate
endmodule

// File: rtl/gm_period_calc.sv
// Module: combinational period and on-time ceiling for the next period.
// The base period is nominal plus dither. Light load adds off-time only,
// capped at the frequency floor. The on-time ceiling is a per-mille
// fraction of the base period.
// Assumes: callers latch the outputs at a period boundary.
module gm_period_calc #(
    parameter int FB_W        = 8,
    parameter int PER_W       = 7,
    parameter int OFF_W       = 3,
    parameter int PERIOD_NOM  = 40,
    parameter int PERIOD_MAX  = 118,
    parameter int GREEN_TH    = 160,
    parameter int GREEN_SLOPE = 2,
    parameter int DUTY_PM     = 895
) (
    input  logic [FB_W-1:0]         fb_code,
    input  logic signed [OFF_W-1:0] offset,
    output logic [PER_W-1:0]        per,
    output logic [PER_W-1:0]        on_lim
);
    localparam int EXT_MAX = PERIOD_MAX - PERIOD_NOM;

    int base_i;
    int ext_i;
    int fb_i;

    // Work out the base period, the green extension and the duty ceiling.
    always_comb begin
        fb_i   = int'(fb_code);
        base_i = PERIOD_NOM + int'(offset);
        if (fb_i >= GREEN_TH) begin
            ext_i = 0;
        end else begin
            ext_i = (GREEN_TH - fb_i) * GREEN_SLOPE;
            if (ext_i > EXT_MAX) begin
                ext_i = EXT_MAX;
            end
        end
        per    = PER_W'(base_i + ext_i);
        on_lim = PER_W'((base_i * DUTY_PM) / 1000);
    end
endmodule

// File: rtl/gm_burst.sv
// Module: zero-duty detector with hysteresis on the feedback code.
// Assumes: ZD_ON > ZD_OFF; the stop flag is sampled at period boundaries.
module gm_burst #(
    parameter int FB_W   = 8,
    parameter int ZD_OFF = 100,
    parameter int ZD_ON  = 108
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    output logic            stop
);
    logic stop_q;

    // Enter stop below the low threshold and leave it at the high one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (fb_code < FB_W'(ZD_OFF)) begin
            stop_q <= 1'b1;
        end else if (fb_code >= FB_W'(ZD_ON)) begin
            stop_q <= 1'b0;
        end
    end

    assign stop = stop_q;
endmodule

// File: rtl/gm_softstart.sv
// Module: soft-start ramp of the peak-current limit code.
// Assumes: en low holds the ramp at zero; it rises by one every STEP clocks.
module gm_softstart #(
    parameter int ILIM_W = 8,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [ILIM_W-1:0] ilim
);
    localparam int              PC_W = $clog2(STEP + 1);
    localparam logic [ILIM_W-1:0] FULL = '1;

    logic [PC_W-1:0]   pc_q;
    logic [ILIM_W-1:0] lim_q;

    // Count prescaler clocks and raise the limit until it saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pc_q  <= '0;
            lim_q <= '0;
        end else if (lim_q != FULL) begin
            if (pc_q == PC_W'(STEP - 1)) begin
                pc_q  <= '0;
                lim_q <= lim_q + ILIM_W'(1);
            end else begin
                pc_q <= pc_q + PC_W'(1);
            end
        end
    end

    assign ilim = lim_q;
endmodule

// File: rtl/gm_pwm_osc.sv
// Module: green-mode jittered PWM oscillator (top). It times each
// switching period, drives the gate with a duty ceiling and leading-edge
// blanking, ends the on-time on a current-limit trip, skips pulses in
// burst stop and ramps a soft-start limit.
// Assumes: fb_code and cl_trip are synchronous to clk.
module gm_pwm_osc
    import gm_pwm_pkg::*;
#(
    parameter int FB_W        = 8,
    parameter int PERIOD_NOM  = 40,
    parameter int PERIOD_MAX  = 118,
    parameter int DUTY_PM     = 895,
    parameter int LEB_CYC     = 6,
    parameter int GREEN_TH    = 160,
    parameter int GREEN_SLOPE = 2,
    parameter int ZD_OFF      = 100,
    parameter int ZD_ON       = 108,
    parameter int JIT_AMP     = 3,
    parameter int JIT_HOLD    = 2,
    parameter int ILIM_W      = 8,
    parameter int SS_STEP     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [FB_W-1:0]   fb_code,
    input  logic              cl_trip,
    output logic              gate,
    output logic              blank,
    output logic              cycle_start,
    output logic [ILIM_W-1:0] ilim
);
    localparam int PER_W = $clog2(PERIOD_MAX + JIT_AMP + 1);
    localparam int OFF_W = $clog2(JIT_AMP + 1) + 1;

    phase_e              phase_q;
    logic [PER_W-1:0]    cnt_q;
    logic [PER_W-1:0]    per_q;
    logic [PER_W-1:0]    onlim_q;
    logic                cs_q;

    logic signed [OFF_W-1:0] jit_off;
    logic [PER_W-1:0]        per_next;
    logic [PER_W-1:0]        on_next;
    logic                    stop;
    logic                    boundary;
    logic                    end_on;
    logic                    trip_hit;
    logic                    blank_w;

    gm_jitter #(
        .AMP   (JIT_AMP),
        .HOLD  (JIT_HOLD),
        .OFF_W (OFF_W)
    ) u_jitter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!enable),
        .adv    (boundary),
        .offset (jit_off)
    );

    gm_period_calc #(
        .FB_W        (FB_W),
        .PER_W       (PER_W),
        .OFF_W       (OFF_W),
        .PERIOD_NOM  (PERIOD_NOM),
        .PERIOD_MAX  (PERIOD_MAX),
        .GREEN_TH    (GREEN_TH),
        .GREEN_SLOPE (GREEN_SLOPE),
        .DUTY_PM     (DUTY_PM)
    ) u_calc (
        .fb_code (fb_code),
        .offset  (jit_off),
        .per     (per_next),
        .on_lim  (on_next)
    );

    gm_burst #(
        .FB_W   (FB_W),
        .ZD_OFF (ZD_OFF),
        .ZD_ON  (ZD_ON)
    ) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_code (fb_code),
        .stop    (stop)
    );

    gm_softstart #(
        .ILIM_W (ILIM_W),
        .STEP   (SS_STEP)
    ) u_ss (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable),
        .ilim  (ilim)
    );

    // Decode the period boundary, blanking, duty end and trip from state.
    always_comb begin
        boundary = enable && ((phase_q == PH_IDLE) || (cnt_q == per_q - PER_W'(1)));
        blank_w  = (phase_q == PH_ON) && (cnt_q < PER_W'(LEB_CYC));
        end_on   = (cnt_q + PER_W'(1)) >= onlim_q;
        trip_hit = cl_trip && (phase_q == PH_ON) && !blank_w;
    end

    // Advance the period counter and the gate phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
            onlim_q <= '0;
            cs_q    <= 1'b0;
        end else if (!enable) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cs_q    <= 1'b0;
        end else if (boundary) begin
            cnt_q   <= '0;
            per_q   <= per_next;
            onlim_q <= on_next;
            phase_q <= stop ? PH_SKIP : PH_ON;
            cs_q    <= !stop;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
            cs_q  <= 1'b0;
            if ((phase_q == PH_ON) && (end_on || trip_hit)) begin
                phase_q <= PH_OFF;
            end
        end
    end

    assign gate        = (phase_q == PH_ON);
    assign blank       = blank_w;
    assign cycle_start = cs_q;
endmodule

// File: rtl/gm_pwm_osc_chk.sv
// Module: property checker for gm_pwm_osc, attached by bind.
// Assumes: it sees only the top-level ports; run lengths are kept in local counters.
module gm_pwm_osc_chk #(
    parameter int FB_W       = 8,
    parameter int PERIOD_NOM = 40,
    parameter int DUTY_PM    = 895,
    parameter int LEB_CYC    = 6,
    parameter int ZD_OFF     = 100,
    parameter int JIT_AMP    = 3,
    parameter int ILIM_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [FB_W-1:0]   fb_code,
    input logic              cl_trip,
    input logic              gate,
    input logic              blank,
    input logic              cycle_start,
    input logic [ILIM_W-1:0] ilim
);
    localparam int ON_MAX  = ((PERIOD_NOM + JIT_AMP) * DUTY_PM) / 1000;
    localparam int PER_MIN = PERIOD_NOM - JIT_AMP;

    logic [15:0] run_q;
    logic [15:0] since_q;

    // Count earlier consecutive gate-high clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) run_q <= '0;
        else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
    end

    // Count clocks since the last cycle start (saturating, preset when idle).
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) since_q <= 16'hFFFF;
        else if (cycle_start) since_q <= '0;
        else if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
    end

    p_max_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (run_q < 16'(ON_MAX)));
    p_blank_in_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> gate);
    p_blank_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (run_q < 16'(LEB_CYC)));
    p_trip_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !blank && cl_trip) |=> (!gate || cycle_start));
    p_rise_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> cycle_start);
    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);
    p_min_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (since_q >= 16'(PER_MIN - 1)));
    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate && (ilim == '0)));
    p_ramp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && enable) |-> ((ilim == $past(ilim)) || (ilim == $past(ilim) + ILIM_W'(1))));
    p_burst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fb_code, 2) < FB_W'(ZD_OFF)) |-> !cycle_start);
endmodule

bind gm_pwm_osc gm_pwm_osc_chk #(
    .FB_W       (FB_W),
    .PERIOD_NOM (PERIOD_NOM),
    .DUTY_PM    (DUTY_PM),
    .LEB_CYC    (LEB_CYC),
    .ZD_OFF     (ZD_OFF),
    .JIT_AMP    (JIT_AMP),
    .ILIM_W     (ILIM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .fb_code     (fb_code),
    .cl_trip     (cl_trip),
    .gate        (gate),
    .blank       (blank),
    .cycle_start (cycle_start),
    .ilim        (ilim)
);

// File: tb/gm_pwm_osc_tb_top.sv
// Bench: self-checking test of gm_pwm_osc. A vector table of feedback codes
// is walked by one loop, followed by directed tests of dither, blanking,
// trips, burst hysteresis, disable and soft-start.
module gm_pwm_osc_tb_top;
    localparam int NOM   = 40;
    localparam int PMAX  = 118;
    localparam int DPM   = 895;
    localparam int LEB   = 6;
    localparam int GTH   = 160;
    localparam int SLOPE = 2;
    localparam int ZOFF  = 100;
    localparam int ZON   = 108;
    localparam int AMP   = 3;
    localparam int HOLD  = 2;
    localparam int SSTEP = 8;
    localparam int NVEC  = 8;

    // Feedback code and the off-time extension the requirements predict for it.
    localparam int VEC_FB [NVEC] = '{200, 160, 159, 150, 130, 122, 121, 112};
    localparam int VEC_EXT[NVEC] = '{  0,   0,   2,  20,  60,  76,  78,  78};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] fb_code = 8'd200;
    logic       cl_trip = 1'b0;
    logic       gate;
    logic       blank;
    logic       cycle_start;
    logic [7:0] ilim;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    gm_pwm_osc #(
        .FB_W(8), .PERIOD_NOM(NOM), .PERIOD_MAX(PMAX), .DUTY_PM(DPM),
        .LEB_CYC(LEB), .GREEN_TH(GTH), .GREEN_SLOPE(SLOPE), .ZD_OFF(ZOFF),
        .ZD_ON(ZON), .JIT_AMP(AMP), .JIT_HOLD(HOLD), .ILIM_W(8), .SS_STEP(SSTEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fb_code(fb_code),
        .cl_trip(cl_trip), .gate(gate), .blank(blank),
        .cycle_start(cycle_start), .ilim(ilim)
    );

    // Dither offset of period k after enable (R4).
    function automatic int jit_of(input int k);
        int s;
        int p;
        s = k / HOLD;
        p = s % (4 * AMP);
        if (p <= AMP) return p;
        else if (p <= 3 * AMP) return 2 * AMP - p;
        else return p - 4 * AMP;
    endfunction

    // On-time ceiling for a dither offset (R5).
    function automatic int on_of(input int j);
        return ((NOM + j) * DPM) / 1000;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Wait at falling edges until cycle_start is seen, with a bound.
    task automatic wait_cs(output int found);
        found = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (cycle_start) begin
                found = 1;
                break;
            end
        end
    endtask

    // Measure one period that starts at the current falling edge (cycle_start high).
    task automatic measure(input int trip_at, output int per, output int on,
                           output int nb, output int cs_twice);
        per = 0; on = 0; nb = 0; cs_twice = 0;
        for (int i = 0; i < 1000; i++) begin
            on += int'(gate);
            nb += int'(blank);
            cl_trip = (i == trip_at);
            @(negedge clk);
            per = i + 1;
            if (cycle_start) begin
                if (i == 0) cs_twice = 1;
                break;
            end
        end
        cl_trip = 1'b0;
    endtask

    // Disable, load a feedback code, enable and align to the first strobe.
    task automatic restart(input int fb);
        int f;
        @(negedge clk);
        enable  = 1'b0;
        fb_code = 8'(fb);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_cs(f);
        check("R10 first period starts after enable", f, 1);
    endtask

    // Count gate-high clocks and strobes over a window.
    task automatic window(input int n, output int g, output int c);
        g = 0; c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            g += int'(gate);
            c += int'(cycle_start);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin : main
        int per, on, nb, cs2, g, c, f;

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1 gate in reset", int'(gate), 0);
        check("R1 strobe in reset", int'(cycle_start), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 gate idle", int'(gate), 0);
        check("R1 blank idle", int'(blank), 0);
        check("R1 ilim idle", int'(ilim), 0);

        // Vector table: R2, R3, R5 with dither from R4
        for (int v = 0; v < NVEC; v++) begin
            restart(VEC_FB[v]);
            for (int k = 0; k < 6; k++) begin
                measure(-1, per, on, nb, cs2);
                check($sformatf("R2/R3 period fb=%0d k=%0d", VEC_FB[v], k),
                      per, NOM + jit_of(k) + VEC_EXT[v]);
                check($sformatf("R5 on-time fb=%0d k=%0d", VEC_FB[v], k),
                      on, on_of(jit_of(k)));
                if (k == 0) begin
                    check("R6 blank length", nb, LEB);
                    check("R11 strobe one clock", cs2, 0);
                end
            end
        end

        // R4: full dither triangle
        restart(200);
        for (int k = 0; k < 24; k++) begin
            measure(-1, per, on, nb, cs2);
            check($sformatf("R4 dither period k=%0d", k), per, NOM + jit_of(k));
        end

        // R6 / R7: trips inside and outside blanking
        restart(200);
        measure(LEB - 1, per, on, nb, cs2);
        check("R6 trip in blank ignored", on, on_of(0));
        measure(LEB, per, on, nb, cs2);
        check("R7 trip at blank end", on, LEB + 1);
        check("R7 period kept", per, NOM + jit_of(1));
        measure(-1, per, on, nb, cs2);
        check("R7 next period full", on, on_of(jit_of(2)));
        measure(20, per, on, nb, cs2);
        check("R7 trip mid on-time", on, 21);

        // R10: disable while gate high, then restart with fresh dither
        enable = 1'b0;
        @(negedge clk);
        check("R10 gate low after disable", int'(gate), 0);
        check("R10 ilim cleared", int'(ilim), 0);
        enable = 1'b1;
        @(negedge clk);
        check("R10 strobe on first enabled edge", int'(cycle_start), 1);
        measure(-1, per, on, nb, cs2);
        check("R10 dither restarted", per, NOM);

        // R8: burst hysteresis
        fb_code = 8'd90;
        window(130, g, c);
        window(400, g, c);
        check("R8 stopped below low threshold", g + c, 0);
        fb_code = 8'd104;
        window(400, g, c);
        check("R8 still stopped inside band", g + c, 0);
        fb_code = 8'd108;
        window(300, g, c);
        check("R8 resumed at high threshold", int'(c > 0), 1);
        fb_code = 8'd104;
        window(130, g, c);
        window(300, g, c);
        check("R8 keeps running inside band", int'(c > 0), 1);
        fb_code = 8'd100;
        window(300, g, c);
        check("R8 runs at low threshold", int'(c > 0), 1);
        fb_code = 8'd99;
        window(130, g, c);
        window(400, g, c);
        check("R8 stopped one below low threshold", g + c, 0);

        // R9: soft-start ramp and saturation
        @(negedge clk);
        enable  = 1'b0;
        fb_code = 8'd200;
        repeat (3) @(negedge clk);
        check("R10 ilim zero while disabled", int'(ilim), 0);
        enable = 1'b1;
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R9 ramp after 80 clocks", int'(ilim), 80 / SSTEP);
        repeat (2100) @(posedge clk);
        @(negedge clk);
        check("R9 ramp saturates", int'(ilim), 255);
        wait_cs(f);
        check("R2 still switching", f, 1);

        report();
    end
endmodule